// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is an 8-bit up-counter driven by a selectable clock prescaler and controlled through a small byte-addressed register bus. In watchdog mode, software must rewrite the counter, normally with 0x00, before it wraps. If the counter wraps, the block raises an external overflow pulse of fixed length. If enabled, it also raises an internal chip-reset pulse that is longer and tagged as either a power-on or a manual reset.

Reads are plain byte accesses. Writes are guarded against stray stores. Each write is a 16-bit word: the upper byte is a key that selects which field changes, and the lower byte carries the data. A word with an unknown key is dropped. The synchronous `rst` input is the external reset. It clears every register and both pulses, and it overrides a watchdog overflow that lands on the same clock edge.

Top module: `wdt_keyed`

## Requirements
- R1: After `rst`, every readable byte is 0x00 and `ovf_out`, `int_rst` and `int_rst_manual` are 0.
- R2: Reads return the following, and 0x00 whenever `bus_rd` is 0:
  - Offset 0: the control byte. Bit 6 is watchdog mode, bit 5 is run-enable, bits 2:0 are the clock select, and bits 7, 4 and 3 read 0.
  - Offset 1: the counter.
  - Offset 3: the reset-control byte. Bit 7 is the overflow flag, bit 6 is reset-enable, bit 5 is reset-type, and bits 4:0 read 0.
  - Offset 2: always 0x00.
- R3: A write to offset 0 with key 0x5A loads the counter from the low byte. A write with key 0xA5 loads the control byte from the low byte. A write with any other key changes neither.
- R4: A write to offset 2 behaves as follows:
  - Word 0xA500 clears the overflow flag.
  - Key 0x5A loads reset-enable from bit 6 and reset-type from bit 5 of the low byte.
  - Key 0xA5 with a non-zero low byte, or any other key, changes nothing.
- R5: Clock select 0 to 7 advances the counter once every 2, 8, 32, 64, 256, 512, 1024 and 4096 cycles respectively.
- R6: While run-enable is 0, the counter holds 0x00 and counter writes have no effect.
- R7: In watchdog mode with run-enable set, a wrap from 0xFF to 0x00 raises `ovf_out` for exactly 128 cycles and sets the overflow flag.
- R8: With watchdog mode 0 the counter still wraps, but no pulse is produced and the flag is unchanged.
- R9: If reset-enable is 1 at a watchdog wrap, `int_rst` is high for exactly 512 cycles and rises in the same cycle as `ovf_out`. If reset-enable is 0, `int_rst` stays low.
- R10: `int_rst_manual` is high exactly while `int_rst` is high, but only when reset-type was 1 at the wrap. Reset-type 1 means manual and 0 means power-on.
- R11: The overflow flag stays set until the 0xA500 clear word or `rst`.
- R12: If `rst` is asserted on the same edge as a watchdog wrap, no pulse follows and the flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External synchronous reset, active high |
| bus_addr | input | 2 | Byte offset within the block |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write word: key in 15:8, data in 7:0 |
| bus_rdata | output | 8 | Read byte |
| ovf_out | output | 1 | External overflow pulse |
| int_rst | output | 1 | Internal reset pulse |
| int_rst_manual | output | 1 | High while `int_rst` is high and the reset is of the manual type |

## Verification
The critical coincidence is the external reset arriving on the very edge at which a watchdog wrap would be registered. The bench first runs a fixed arming sequence from reset and counts the cycles until `ovf_out` rises. It then repeats the identical sequence and drives `rst` across the edge just before that count. The design passes if neither pulse appears and the reset-control byte reads back 0x00.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned NUM_TAPS = 8;
    localparam int unsigned SEL_W    = $clog2(NUM_TAPS);

    localparam logic [BYTE_W-1:0] KEY_DATA = 8'h5A;
    localparam logic [BYTE_W-1:0] KEY_CTRL = 8'hA5;

    typedef enum logic [1:0] {
        OFS_CTRL   = 2'd0,
        OFS_COUNT  = 2'd1,
        OFS_RCTL_W = 2'd2,
        OFS_RCTL_R = 2'd3
    } ofs_e;

    typedef struct packed {
        logic             wd_mode;
        logic             run;
        logic [SEL_W-1:0] clk_sel;
    } ctrl_t;

    typedef struct packed {
        logic ovf_flag;
        logic rst_en;
        logic rst_manual;
    } rctl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] key;
        logic [BYTE_W-1:0] val;
    } wword_t;

    // log2 of the divide ratio for each clock-select code
    function automatic int unsigned tap_log2(int unsigned idx);
        case (idx)
            0:       return 1;
            1:       return 3;
            2:       return 5;
            3:       return 6;
            4:       return 8;
            5:       return 9;
            6:       return 10;
            default: return 12;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_byte(ctrl_t c);
        return {1'b0, c.wd_mode, c.run, 2'b00, c.clk_sel};
    endfunction

    function automatic ctrl_t ctrl_from(logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.wd_mode = b[6];
        c.run     = b[5];
        c.clk_sel = b[SEL_W-1:0];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] rctl_byte(rctl_t r);
        return {r.ovf_flag, r.rst_en, r.rst_manual, 5'b00000};
    endfunction

endpackage

// File: rtl/wdk_prescaler.sv
`timescale 1ns/1ps
module wdk_prescaler
    import wdk_pkg::*;
#(
    parameter int unsigned PRE_W = tap_log2(NUM_TAPS - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] clk_sel,
    output logic             tick
);

    logic [PRE_W-1:0]    pcnt_q;
    logic [NUM_TAPS-1:0] tap_hit;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // One terminal-count detector per divide ratio
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int unsigned TAP_L = tap_log2(g);
        assign tap_hit[g] = &pcnt_q[TAP_L-1:0];
    end

    assign tick = run && tap_hit[clk_sel];

endmodule

// File: rtl/wdk_counter.sv
`timescale 1ns/1ps
module wdk_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    // A software reload on the same edge suppresses the wrap
    assign wrap = run && tick && !load && (&count);

endmodule

// File: rtl/wdk_pulse.sv
`timescale 1ns/1ps
module wdk_pulse #(
    parameter int unsigned LEN = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);

    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= CW'(LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active = (left_q != '0);

endmodule

// File: rtl/wdk_regbus.sv
`timescale 1ns/1ps
module wdk_regbus
    import wdk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    input  logic [BYTE_W-1:0] count,
    input  logic              wd_event,
    output ctrl_t             ctrl,
    output rctl_t             rctl,
    output logic              cnt_load,
    output logic [BYTE_W-1:0] cnt_wval,
    output logic [BYTE_W-1:0] rdata
);

    wword_t w;
    logic   at_main, at_rctl;
    logic   ctrl_we, cfg_we, flag_clr;

    assign w        = wword_t'(bus_wdata);
    assign at_main  = bus_wr && (ofs_e'(bus_addr) == OFS_CTRL);
    assign at_rctl  = bus_wr && (ofs_e'(bus_addr) == OFS_RCTL_W);

    assign cnt_load = at_main && (w.key == KEY_DATA);
    assign cnt_wval = w.val;
    assign ctrl_we  = at_main && (w.key == KEY_CTRL);
    assign cfg_we   = at_rctl && (w.key == KEY_DATA);
    assign flag_clr = at_rctl && (w.key == KEY_CTRL) && (w.val == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            rctl <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl <= ctrl_from(w.val);
            end
            if (cfg_we) begin
                rctl.rst_en     <= w.val[6];
                rctl.rst_manual <= w.val[5];
            end
            // a new overflow beats a coincident clear
            if (wd_event) begin
                rctl.ovf_flag <= 1'b1;
            end else if (flag_clr) begin
                rctl.ovf_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (bus_rd) begin
            case (ofs_e'(bus_addr))
                OFS_CTRL:   rdata = ctrl_byte(ctrl);
                OFS_COUNT:  rdata = count;
                OFS_RCTL_R: rdata = rctl_byte(rctl);
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
    import wdk_pkg::*;
#(
    parameter int unsigned OVF_LEN = 128,
    parameter int unsigned RST_LEN = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        ovf_out,
    output logic        int_rst,
    output logic        int_rst_manual
);

    ctrl_t             ctrl;
    rctl_t             rctl;
    logic              tick, wrap, cnt_load;
    logic [BYTE_W-1:0] cnt_val, cnt_wval;
    logic              wd_event, rst_fire, kind_q;
    logic              ovf_flag, run_en;
    logic [4:0]        ctrl_bits;

    assign wd_event  = wrap && ctrl.wd_mode;
    assign rst_fire  = wd_event && rctl.rst_en;
    assign ovf_flag  = rctl.ovf_flag;
    assign run_en    = ctrl.run;
    assign ctrl_bits = ctrl;

    wdk_regbus u_regbus (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .count    (cnt_val),
        .wd_event (wd_event),
        .ctrl     (ctrl),
        .rctl     (rctl),
        .cnt_load (cnt_load),
        .cnt_wval (cnt_wval),
        .rdata    (bus_rdata)
    );

    wdk_prescaler u_presc (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl.run),
        .clk_sel(ctrl.clk_sel),
        .tick   (tick)
    );

    wdk_counter #(.CNT_W(BYTE_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .tick    (tick),
        .load    (cnt_load),
        .load_val(cnt_wval),
        .count   (cnt_val),
        .wrap    (wrap)
    );

    wdk_pulse #(.LEN(OVF_LEN)) u_ovf_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (wd_event),
        .active(ovf_out)
    );

    wdk_pulse #(.LEN(RST_LEN)) u_rst_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (rst_fire),
        .active(int_rst)
    );

    // reset type is captured when the pulse starts
    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= 1'b0;
        end else if (rst_fire) begin
            kind_q <= rctl.rst_manual;
        end
    end

    assign int_rst_manual = int_rst && kind_q;

endmodule

// File: rtl/wdk_checker.sv
`timescale 1ns/1ps
module wdk_checker #(
    parameter int unsigned OVF_LEN = 128,
    parameter int unsigned RST_LEN = 512
) (
    input logic        clk,
    input logic        rst,
    input logic        ovf_out,
    input logic        int_rst,
    input logic        ovf_flag,
    input logic        run_en,
    input logic [7:0]  cnt_val,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [4:0]  ctrl_bits
);

    logic [15:0] ovf_run, rst_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_run <= '0;
            rst_run <= '0;
        end else begin
            ovf_run <= ovf_out ? ovf_run + 1'b1 : '0;
            rst_run <= int_rst ? rst_run + 1'b1 : '0;
        end
    end

    AST_OVF_LEN_MAX: assert property (@(posedge clk) disable iff (rst)
        ovf_run <= 16'(OVF_LEN)); // R7
    AST_OVF_LEN_EXACT: assert property (@(posedge clk) disable iff (rst)
        ($fell(ovf_out) && !$past(rst)) |-> (ovf_run == 16'(OVF_LEN))); // R7
    AST_RST_LEN_EXACT: assert property (@(posedge clk) disable iff (rst)
        ($fell(int_rst) && !$past(rst)) |-> (rst_run == 16'(RST_LEN))); // R9
    AST_RST_WITH_OVF: assert property (@(posedge clk) disable iff (rst)
        $rose(int_rst) |-> $rose(ovf_out)); // R9
    AST_FLAG_ON_OVF: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_out) |-> ovf_flag); // R7
    AST_EXT_RST_WINS: assert property (@(posedge clk)
        rst |=> (!ovf_out && !int_rst && !ovf_flag)); // R12
    AST_HELD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(run_en) |-> (cnt_val == 8'h00)); // R6
    AST_KEY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[15:8] != 8'h5A && bus_wdata[15:8] != 8'hA5)
        |=> $stable(ctrl_bits)); // R3

endmodule

bind wdt_keyed wdk_checker #(.OVF_LEN(OVF_LEN), .RST_LEN(RST_LEN)) u_wdk_chk (
    .clk      (clk),
    .rst      (rst),
    .ovf_out  (ovf_out),
    .int_rst  (int_rst),
    .ovf_flag (ovf_flag),
    .run_en   (run_en),
    .cnt_val  (cnt_val),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .ctrl_bits(ctrl_bits)
);

// File: tb/wdt_keyed_bench.sv
`timescale 1ns/1ps
module wdt_keyed_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ovf_out, int_rst, int_rst_manual;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    wdt_keyed u_wdt_keyed (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .ovf_out       (ovf_out),
        .int_rst       (int_rst),
        .int_rst_manual(int_rst_manual)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        v        = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_ovf(output int n);
        n = 0;
        #1;
        while (!ovf_out && n < 300) begin
            @(negedge clk);
            #1;
            n++;
        end
    endtask

    // counts pulse cycles starting at the current (rising) cycle
    task automatic measure(output int n_ovf, output int n_rst, output int n_man, output int n_mis);
        n_ovf = 0; n_rst = 0; n_man = 0; n_mis = 0;
        for (int i = 0; i < 700; i++) begin
            n_ovf += int'(ovf_out);
            n_rst += int'(int_rst);
            n_man += int'(int_rst_manual);
            if (int_rst_manual && !int_rst) n_mis++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic arm_for_clash();
        do_reset();
        wr(2'd0, 16'hA560);
        wr(2'd2, 16'h5A40);
        wr(2'd0, 16'h5AFF);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, prev;
        int n, n_ovf, n_rst, n_man, n_mis, seen_pulse, n_clash;

        // R1: reset state
        do_reset();
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check($sformatf("R1 byte %0d after reset", a), v, 0);
        end
        check("R1 ovf_out after reset", ovf_out, 0);
        check("R1 int_rst after reset", int_rst, 0);
        check("R1 int_rst_manual after reset", int_rst_manual, 0);

        // R2/R3: keyed writes to the control byte and counter
        wr(2'd0, 16'hA5FF);
        rd(2'd0, v);  check("R2 R3 control byte readback", v, 8'h67);
        wr(2'd0, 16'h5A40);
        rd(2'd1, v);  check("R3 counter load with key 0x5A", v, 8'h40);
        wr(2'd0, 16'h3300);
        rd(2'd0, v);  check("R3 bad key leaves control", v, 8'h67);
        wr(2'd0, 16'hA410);
        rd(2'd0, v);  check("R3 near key leaves control", v, 8'h67);
        rd(2'd1, v);  check("R3 bad key leaves counter", v, 8'h40);
        rd(2'd2, v);  check("R2 offset 2 reads zero", v, 0);
        @(negedge clk); bus_addr = 2'd1; #1;
        check("R2 no read strobe gives zero", bus_rdata, 0);

        // R4: reset-control field updates
        wr(2'd2, 16'h5AFF);
        rd(2'd3, v);  check("R4 config key sets both bits", v, 8'h60);
        wr(2'd2, 16'h5A20);
        rd(2'd3, v);  check("R4 config key loads type only", v, 8'h20);
        wr(2'd2, 16'h3340);
        rd(2'd3, v);  check("R4 bad key ignored", v, 8'h20);
        wr(2'd2, 16'h5A00);
        rd(2'd3, v);  check("R4 config key clears bits", v, 8'h00);

        // R6: disabled counter holds zero
        wr(2'd0, 16'hA540);
        wr(2'd0, 16'h5A80);
        rd(2'd1, v);  check("R6 counter write while stopped", v, 0);
        repeat (20) @(negedge clk);
        rd(2'd1, v);  check("R6 counter stays zero", v, 0);

        // R5: sweep of every clock select
        do_reset();
        for (int s = 0; s < 8; s++) begin
            int lg;
            lg = (s == 0) ? 1 : (s == 1) ? 3 : (s == 2) ? 5 : (s == 3) ? 6 :
                 (s == 4) ? 8 : (s == 5) ? 9 : (s == 6) ? 10 : 12;
            wr(2'd0, 16'hA520 | 16'(s));
            rd(2'd1, prev);
            n = 0;
            do begin rd(2'd1, v); n++; end while (v == prev && n < 9000);
            prev = v;
            n = 0;
            do begin rd(2'd1, v); n++; end while (v == prev && n < 9000);
            check($sformatf("R5 step period sel %0d", s), n, 1 << lg);
        end

        // R8: interval mode wraps silently
        do_reset();
        wr(2'd0, 16'hA520);
        wr(2'd2, 16'h5A40);
        wr(2'd0, 16'h5AFE);
        seen_pulse = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (ovf_out || int_rst) seen_pulse++;
        end
        check("R8 no pulse in interval mode", seen_pulse, 0);
        rd(2'd1, v);  check("R8 counter wrapped", int'(v < 8'h20), 1);
        rd(2'd3, v);  check("R8 flag unchanged", v, 8'h40);

        // R7/R9/R10/R11: watchdog overflow with manual reset
        do_reset();
        wr(2'd0, 16'hA561);
        wr(2'd2, 16'h5A60);
        wr(2'd0, 16'h5AFE);
        wait_ovf(n);
        check("R7 overflow pulse appears", ovf_out, 1);
        check("R9 int_rst rises with ovf_out", int_rst, 1);
        check("R10 manual type flagged", int_rst_manual, 1);
        measure(n_ovf, n_rst, n_man, n_mis);
        check("R7 ovf_out width", n_ovf, 128);
        check("R9 int_rst width", n_rst, 512);
        check("R10 manual tag width", n_man, 512);
        check("R10 tag only inside reset", n_mis, 0);
        wr(2'd0, 16'hA501);
        rd(2'd3, v);  check("R7 R11 flag set after overflow", v, 8'hE0);
        wr(2'd2, 16'hA501);
        rd(2'd3, v);  check("R4 R11 clear with nonzero data ignored", v, 8'hE0);
        wr(2'd2, 16'h3300);
        rd(2'd3, v);  check("R11 flag holds on bad key", v, 8'hE0);
        wr(2'd2, 16'hA500);
        rd(2'd3, v);  check("R4 R11 clear word drops flag", v, 8'h60);

        // R9: reset disabled gives overflow pulse only
        wr(2'd2, 16'h5A00);
        wr(2'd0, 16'hA561);
        wr(2'd0, 16'h5AFE);
        wait_ovf(n);
        measure(n_ovf, n_rst, n_man, n_mis);
        check("R9 no int_rst when disabled", n_rst, 0);
        check("R7 ovf_out width again", n_ovf, 128);

        // R10: power-on type
        wr(2'd2, 16'h5A40);
        wr(2'd0, 16'h5AFE);
        wait_ovf(n);
        measure(n_ovf, n_rst, n_man, n_mis);
        check("R9 int_rst width power-on", n_rst, 512);
        check("R10 power-on reset not tagged manual", n_man, 0);
        wr(2'd0, 16'hA500);

        // R12: external reset on the overflow edge
        arm_for_clash();
        wait_ovf(n_clash);
        check("R12 reference overflow found", int'(n_clash >= 1 && n_clash < 300), 1);
        arm_for_clash();
        #1;
        for (int i = 0; i < n_clash - 1; i++) begin
            @(negedge clk); #1;
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        seen_pulse = 0;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (ovf_out || int_rst) seen_pulse++;
            @(negedge clk);
        end
        check("R12 no pulse after coincident reset", seen_pulse, 0);
        rd(2'd3, v);  check("R12 flag cleared", v, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule